// File: doc/BRIEF.md
# Byte Register Access Target on a Two-Wire Serial Bus

This block lets a controller on a two-wire serial bus (I2C, standard mode up to 100 kHz) read and write a byte-wide register space. It uses a register pointer that the block holds internally. A fast system clock samples the SCL and SDA lines through synchronizers. The block finds the bus edges and its START, repeated START and STOP conditions from those synchronized samples. It answers by enabling an open-drain pull-down on SDA.

The 7-bit target address has two parts. The upper five bits are fixed by a parameter. The lower two bits come from two address pins, which are read at the moment the address byte is checked and are never latched.

In a write transaction, the first byte after the address loads the pointer. Each later byte is written at the pointer, and the pointer then moves up by one. In a read transaction, bytes come from the pointer, and the pointer moves up by one for each byte fetched. A write that carries only the pointer byte, followed by STOP or by a repeated START, sets up a later read. A simple strobe bus connects the block to the register file, and the read data on that bus is taken combinationally.

Top module: `i2c_reg_target`

## Requirements
- R1: The block pulls SDA low for the whole ninth clock when the address byte matches. The match is on bits 7..1 of that byte equal to {01011, addr_pins[1], addr_pins[0]}, and bit 0 = 0 means write, bit 0 = 1 means read.
- R2: If the address does not match, the block gives no acknowledge. It then ignores the bus, with no acknowledge and no register strobe, until the next START.
- R3: addr_pins are compared at the end of the eighth address bit. A change made after START but before that point is honoured.
- R4: In a write, the first data byte loads the pointer, which is visible on reg_addr. Every byte of the write is acknowledged.
- R5: Each later write byte gives one reg_we pulse, with reg_addr equal to the pointer and reg_wdata equal to the byte. The pointer then increments, wrapping at 8 bits.
- R6: A write with only the pointer byte, ended by STOP or by a repeated START, makes the next read begin at that pointer.
- R7: A read returns the register at the pointer, MSB first. Each byte fetched gives one reg_re pulse and increments the pointer. A controller ACK (SDA low) requests another byte. A NACK (SDA high) ends the read with SDA released.
- R8: A START or STOP in any phase, including mid-byte, aborts the current transfer without any write strobe. STOP releases SDA. The pointer keeps its value across transactions.
- R9: sda_oe changes only while the synchronized SCL is low.
- R10: reg_we and reg_re are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_pins | input | 2 | Live low address bits (bit 1 above bit 0) |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe, data sampled this cycle |
| reg_rdata | input | 8 | Register read data at reg_addr |

## Verification
The bench changes the address pins partway through an address byte. A target that latched the pins at START would withhold the acknowledge there. It ends a read with a NACK and checks both that SDA is released and the pointer value. A design that kept driving would hold the line, and one that fetched one byte too many would leave the pointer one step too far. It also breaks off a write halfway through a data byte with a repeated START, and a read halfway through with a STOP. A block that did not return to the address phase would then write a stray register or never release SDA.

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [4:0] ADDR_PREFIX = 5'b01011,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [1:0] addr_pins,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  output logic       reg_re,
  input  logic [7:0] reg_rdata
);
  localparam int HIST = SYNC_STAGES + 1;

  typedef enum logic [2:0] {IDLE, ADDR, ACK_A, WR, ACK_W, RD, ACK_R} phase_t;

  phase_t          state;
  logic [HIST-1:0] scl_q, sda_q;
  logic [3:0]      cnt;
  logic [7:0]      sr, ptr;
  logic            first, rw, nack;

  wire scl_s = scl_q[SYNC_STAGES-1];
  wire scl_d = scl_q[SYNC_STAGES];
  wire sda_s = sda_q[SYNC_STAGES-1];
  wire sda_d = sda_q[SYNC_STAGES];

  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire byte_end  = scl_fall & (cnt == 4'd8);
  wire addr_hit  = (sr[7:1] == {ADDR_PREFIX, addr_pins});

  assign reg_addr  = ptr;
  assign reg_wdata = sr;
  assign reg_we    = (state == WR) & byte_end & ~first;
  assign reg_re    = scl_fall & (((state == ACK_A) & rw) | ((state == ACK_R) & ~nack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= '1;
      sda_q  <= '1;
      state  <= IDLE;
      cnt    <= '0;
      sr     <= '0;
      ptr    <= '0;
      first  <= 1'b0;
      rw     <= 1'b0;
      nack   <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      scl_q <= {scl_q[HIST-2:0], scl_in};
      sda_q <= {sda_q[HIST-2:0], sda_in};
      if (stop_det) begin
        state  <= IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= ADDR;
        cnt    <= '0;
        first  <= 1'b1;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ADDR: begin
            if (scl_rise) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (byte_end) begin
              if (addr_hit) begin
                sda_oe <= 1'b1;
                rw     <= sr[0];
                state  <= ACK_A;
              end else begin
                state <= IDLE;
              end
            end
          end
          WR: begin
            if (scl_rise) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (byte_end) begin
              sda_oe <= 1'b1;
              state  <= ACK_W;
              first  <= 1'b0;
              ptr    <= first ? sr : ptr + 8'd1;
            end
          end
          ACK_A: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                sr     <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
                ptr    <= ptr + 8'd1;
                state  <= RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= WR;
              end
            end
          end
          ACK_W: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= WR;
            end
          end
          RD: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= ACK_R;
              end else begin
                sda_oe <= ~sr[6];
                sr     <= {sr[6:0], 1'b0};
                cnt    <= cnt + 4'd1;
              end
            end
          end
          ACK_R: begin
            if (scl_rise) begin
              nack <= sda_s;
            end else if (scl_fall) begin
              if (nack) begin
                state <= IDLE;
              end else begin
                sr     <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
                ptr    <= ptr + 8'd1;
                cnt    <= '0;
                state  <= RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));

  assert_we_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_addr == 8'($past(reg_addr) + 8'd1));

  assert_re_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> reg_addr == 8'($past(reg_addr) + 8'd1));

  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_nack_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ADDR && byte_end && !addr_hit) |=> !sda_oe);
endmodule

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       ctrl_scl = 1'b1;
  logic       ctrl_sda = 1'b1;
  logic [1:0] pins = 2'b00;
  logic       sda_oe, reg_we, reg_re;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  wire        sda_line = ctrl_sda & ~sda_oe;

  logic [7:0] mem   [256];
  logic [7:0] model [256];
  logic [7:0] wbuf  [4];

  int checks = 0, errors = 0, we_cnt = 0, r9_bad = 0, r10_bad = 0;
  logic prev_oe = 1'b0;

  assign reg_rdata = mem[reg_addr];

  i2c_reg_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(ctrl_scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .addr_pins(pins), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata)
  );

  always @(negedge clk) begin
    if (reg_we) begin
      mem[reg_addr] = reg_wdata;
      we_cnt++;
    end
    if (reg_we && reg_re) r10_bad++;
    if (rst_n && sda_oe != prev_oe && ctrl_scl) r9_bad++;
    prev_oe = sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    ctrl_sda = 1'b1; q(); ctrl_scl = 1'b1; q(); ctrl_sda = 1'b0; q(); ctrl_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    ctrl_sda = 1'b0; q(); ctrl_scl = 1'b1; q(); ctrl_sda = 1'b1; q(); q();
  endtask

  task automatic put_bit(input bit b);
    ctrl_sda = b; q(); ctrl_scl = 1'b1; q(); q(); ctrl_scl = 1'b0; q();
  endtask

  task automatic get_bit(output bit b);
    ctrl_sda = 1'b1; q(); ctrl_scl = 1'b1; q(); b = sda_line; q(); ctrl_scl = 1'b0; q();
  endtask

  task automatic put_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] v, input bit more);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~more);
  endtask

  function automatic logic [7:0] abyte(input logic [1:0] p, input bit rd);
    return {5'b01011, p, rd};
  endfunction

  task automatic write_txn(input logic [7:0] p, input int n);
    bit ack;
    bus_start();
    put_byte(abyte(pins, 1'b0), ack); chk("R1 address ack", ack, 1);
    put_byte(p, ack);                 chk("R4 pointer ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      put_byte(wbuf[i], ack);         chk("R4 data ack", ack, 1);
      model[8'(p + i)] = wbuf[i];
    end
    bus_stop();
    chk("R4 R5 pointer after write", reg_addr, 8'(p + n));
  endtask

  task automatic read_txn(input logic [7:0] p, input int n, input bit combined);
    bit ack;
    logic [7:0] v;
    if (combined) begin
      bus_start();
      put_byte(abyte(pins, 1'b0), ack); chk("R6 address ack", ack, 1);
      put_byte(p, ack);                 chk("R6 pointer ack", ack, 1);
    end
    bus_start();
    put_byte(abyte(pins, 1'b1), ack);   chk("R1 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(v, i < n - 1);
      chk("R7 read data", v, model[8'(p + i)]);
    end
    q();
    chk("R7 SDA released after NACK", sda_oe, 0);
    bus_stop();
    chk("R7 pointer after read", reg_addr, 8'(p + n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    bit b;
    logic [7:0] v;
    int we0;
    void'($urandom(32'd1127));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'hA5;
      model[i] = 8'(i) ^ 8'hA5;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 reset sda_oe", sda_oe, 0);
    chk("R10 reset strobes", {reg_we, reg_re}, 0);
    chk("R8 reset pointer", reg_addr, 0);

    we0 = we_cnt;
    bus_start();
    put_byte(abyte(2'b01, 1'b0), ack); chk("R2 mismatch no ack", ack, 0);
    put_byte(8'h55, ack);              chk("R2 ignored byte no ack", ack, 0);
    put_byte(8'h66, ack);              chk("R2 ignored byte no ack", ack, 0);
    bus_stop();
    chk("R2 no write strobe", we_cnt - we0, 0);

    pins = 2'b10;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    we0 = we_cnt;
    write_txn(8'h20, 3);
    chk("R5 write strobes", we_cnt - we0, 3);
    chk("R5 mem 0x20", mem[8'h20], 8'h11);
    chk("R5 mem 0x22", mem[8'h22], 8'h33);

    write_txn(8'h20, 0);
    chk("R6 pointer only", reg_addr, 8'h20);
    read_txn(8'h20, 3, 1'b0);
    read_txn(8'h40, 2, 1'b1);

    wbuf[0] = 8'hFE; wbuf[1] = 8'h01;
    write_txn(8'hFF, 2);
    chk("R5 wrap mem 0x00", mem[8'h00], 8'h01);
    read_txn(8'hFF, 2, 1'b1);

    pins = 2'b00;
    bus_start();
    for (int i = 7; i >= 4; i--) put_bit(abyte(2'b11, 1'b0)[i]);
    pins = 2'b11;
    for (int i = 3; i >= 0; i--) put_bit(abyte(2'b11, 1'b0)[i]);
    get_bit(b);
    chk("R3 live pins ack", b, 0);
    bus_stop();
    bus_start();
    put_byte(abyte(2'b00, 1'b0), ack); chk("R3 old pins no ack", ack, 0);
    bus_stop();

    we0 = we_cnt;
    bus_start();
    put_byte(abyte(pins, 1'b0), ack); chk("R1 ack", ack, 1);
    put_byte(8'h10, ack);             chk("R4 ack", ack, 1);
    for (int i = 0; i < 4; i++) put_bit(i[0]);
    bus_start();
    put_byte(abyte(pins, 1'b1), ack); chk("R8 restart address ack", ack, 1);
    get_byte(v, 1'b0);
    chk("R8 read after aborted byte", v, model[8'h10]);
    q();
    bus_stop();
    chk("R8 no write from aborted byte", we_cnt - we0, 0);

    wbuf[0] = 8'hFF;
    write_txn(8'h50, 1);
    bus_start();
    put_byte(abyte(pins, 1'b0), ack);
    put_byte(8'h50, ack);
    bus_start();
    put_byte(abyte(pins, 1'b1), ack); chk("R8 read ack", ack, 1);
    for (int i = 0; i < 4; i++) get_bit(b);
    bus_stop();
    chk("R8 STOP mid read releases", sda_oe, 0);
    chk("R8 pointer kept", reg_addr, 8'h51);
    read_txn(8'h51, 1, 1'b0);

    for (int it = 0; it < 16; it++) begin
      logic [7:0] p;
      int n;
      pins = 2'($urandom);
      p = 8'($urandom);
      n = 1 + int'($urandom % 4);
      for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
      write_txn(p, n);
      read_txn(p, n, 1'b1);
    end

    chk("R9 sda_oe changed while SCL high", r9_bad, 0);
    chk("R10 strobes overlapped", r10_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule